// File: doc/BRIEF.md
# Dual-Compare Timer with PWM Output

This block is a 10-bit up-counter checked against two compare registers, A and P. The counter advances once for each clock in which the prescale enable is high, the run bit is set and the pause bit is clear. Each comparator sets its own sticky flag when the counter steps onto its value. Software clears a flag by writing a 1 to it.

A two-bit mode field selects the operating mode. In PWM mode, a role-swap bit decides which compare register ends the period by clearing the counter. The other register then sets the duty point. In the timer/counter modes, a separate clear-select bit picks the clearing register and the output pin is released.

The pin stage has three controls. A bit selects the active level of the waveform. A second bit inverts the final level. A two-bit output-function field can hold the pin at its inactive or active level, and the counter and flags keep running while it does. All controls are reached through a small write/read register port.

Top module: `dcpwm_timer`

## Requirements
- R1: After reset, all registers read zero, the counter is 0, both flags are clear, and `pin_oe` and `pin_o` are 0.
- R2: Mode field ctrl[3:2] = 2'b10 is PWM mode, in which `pin_oe` is 1. Every other value (11 is the timer/counter mode; 00 and 01 behave the same way) holds `pin_oe` and `pin_o` at 0 while the counter and flags keep working.
- R3: The counter advances by one on each cycle with `tick_en` = 1, run (ctrl[0]) = 1 and pause (ctrl[1]) = 0. With pause set, or with `tick_en` low, the counter holds its value. Clearing pause resumes counting from the held value.
- R4: With run = 0 the counter holds its value. On the first cycle after run becomes 1, the counter loads 0 and does not advance.
- R5: The period register ends the period. If its value V is not 0, the counter goes from V to 0 (a period of V+1 ticks). If V = 0, the counter runs the full 1024 counts and wraps from 1023 to 0. In PWM mode, ctrl[4] = 0 makes P the period register and ctrl[4] = 1 makes A the period register, and ctrl[5] is ignored. In the other modes, ctrl[5] = 0 selects P and ctrl[5] = 1 selects A.
- R6: Flag A (status bit 0) and flag P (status bit 1) are set in the cycle the counter advances onto that register's value, in every mode. A restart to 0 does not set a flag. Writing 1 to a flag bit at address 3 clears it, writing 0 has no effect, and a set in the same cycle wins over a clear.
- R7: In PWM mode, the raw waveform is active while the counter is below the duty register, which is whichever of A and P does not set the period. ctrl[6] = 1 makes active mean high and ctrl[6] = 0 makes active mean low. ctrl[7] = 1 inverts the final pin level.
- R8: The output field ctrl[9:8] selects the pin source: 00 holds the inactive level, 01 holds the active level, and 10 or 11 passes the waveform. ctrl[7] still applies to the held level, and the counter and flags keep running.
- R9: The register map is: address 0 holds ctrl[9:0], address 1 holds A, address 2 holds P, and address 3 reads the counter in bits 15:6 and flags P and A in bits 1:0. Unused read bits are 0. A write to address 3 changes only the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Prescaled count enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address |
| wr_data | input | 10 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 16 | Read data for `rd_addr` (combinational) |
| pin_o | output | 1 | Timer output level |
| pin_oe | output | 1 | High when the timer drives the pin |

## Verification
The embedded assertions check every cycle that the counter:
- holds while stopped, paused or without a tick;
- restarts at 0;
- never passes a non-zero period value.

They also check, every cycle, that a comparator match always leaves its flag set, that written registers take the written value, and that the pin is released outside PWM mode and at the right level when forced.

Only the bench's scenarios show the longer behaviours:
- the 1024-count wrap of a zero period;
- the role swap between A and P;
- the clear-select bit having no effect in PWM mode;
- the duty waveform shape under each polarity and inversion setting.

These scenarios are compared step by step against a reference model built from the requirements.

// File: rtl/dcpwm_pkg.sv
package dcpwm_pkg;

   typedef enum logic [1:0] {
      MODE_CMP0 = 2'b00,
      MODE_CMP1 = 2'b01,
      MODE_PWM  = 2'b10,
      MODE_TMR  = 2'b11
   } mode_e;

   typedef enum logic [1:0] {
      OF_INACT = 2'b00,
      OF_ACT   = 2'b01,
      OF_WAVE  = 2'b10,
      OF_WAVE2 = 2'b11
   } ofunc_e;

   // Packed order places run at bit 0 and the output field at bits 9:8.
   typedef struct packed {
      ofunc_e ofunc;
      logic   invert;
      logic   act_hi;
      logic   clr_on_a;
      logic   swap;
      mode_e  mode;
      logic   pause;
      logic   run;
   } ctrl_t;

   localparam int CTRL_W = $bits(ctrl_t);

   localparam logic [1:0] ADR_CTRL = 2'd0;
   localparam logic [1:0] ADR_CMPA = 2'd1;
   localparam logic [1:0] ADR_CMPP = 2'd2;
   localparam logic [1:0] ADR_STAT = 2'd3;

endpackage

// File: rtl/dcpwm_counter.sv
module dcpwm_counter #(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             run_i,
   input  logic             pause_i,
   input  logic [CNT_W-1:0] period_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic [CNT_W-1:0] nxt_o,
   output logic             adv_o
);

   logic             run_q;
   logic             restart;
   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] inc;

   assign restart = run_i & ~run_q;
   assign adv_o   = tick_i & run_i & ~pause_i & ~restart;
   assign cnt_o   = cnt_q;

   // A zero period value leaves the natural wrap as the only clear.
   always_comb begin
      inc = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
      if ((period_i != '0) && (cnt_q == period_i)) begin
         nxt_o = '0;
      end else begin
         nxt_o = inc;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else begin
         run_q <= run_i;
         if (restart) begin
            cnt_q <= '0;
         end else if (adv_o) begin
            cnt_q <= nxt_o;
         end
      end
   end

   a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (run_i && !run_q) |=> (cnt_q == '0));

   a_r4_stopped_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !run_i |=> $stable(cnt_q));

   a_r3_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (pause_i && run_q) |=> $stable(cnt_q));

   a_r3_no_tick_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && run_q) |=> $stable(cnt_q));

   a_r5_within_period: assert property (@(posedge clk) disable iff (!rst_n)
      (adv_o && (period_i != '0) && (cnt_q <= period_i) && $stable(period_i))
      |=> (cnt_q <= $past(period_i)));

endmodule

// File: rtl/dcpwm_regs.sv
module dcpwm_regs
   import dcpwm_pkg::*;
#(
   parameter int CNT_W = 10,
   parameter int WR_W  = 10,
   parameter int RD_W  = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [WR_W-1:0]  wr_data,
   input  logic [1:0]       rd_addr,
   output logic [RD_W-1:0]  rd_data,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [1:0]       match_i,
   output ctrl_t            ctrl_o,
   output logic [CNT_W-1:0] cmp_a_o,
   output logic [CNT_W-1:0] cmp_p_o
);

   if (WR_W < CTRL_W || WR_W < CNT_W) begin : g_bad_wr
      $error("dcpwm_regs: write width too small");
   end
   if (RD_W < CNT_W + 2 || RD_W < CTRL_W) begin : g_bad_rd
      $error("dcpwm_regs: read width too small");
   end

   ctrl_t            ctrl_q;
   logic [CNT_W-1:0] cmp_a_q;
   logic [CNT_W-1:0] cmp_p_q;
   logic [1:0]       flag_q;
   logic [1:0]       flag_d;
   logic             stat_wr;

   assign stat_wr = wr_en && (wr_addr == ADR_STAT);

   // Set beats clear: the match term is OR-ed after the write-one mask.
   for (genvar k = 0; k < 2; k++) begin : g_flag
      assign flag_d[k] = (flag_q[k] & ~(stat_wr & wr_data[k])) | match_i[k];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q  <= '0;
         cmp_a_q <= '0;
         cmp_p_q <= '0;
         flag_q  <= '0;
      end else begin
         flag_q <= flag_d;
         if (wr_en) begin
            unique case (wr_addr)
               ADR_CTRL: ctrl_q  <= ctrl_t'(wr_data[CTRL_W-1:0]);
               ADR_CMPA: cmp_a_q <= wr_data[CNT_W-1:0];
               ADR_CMPP: cmp_p_q <= wr_data[CNT_W-1:0];
               default:  ;
            endcase
         end
      end
   end

   always_comb begin
      rd_data = '0;
      unique case (rd_addr)
         ADR_CTRL: rd_data[CTRL_W-1:0] = ctrl_q;
         ADR_CMPA: rd_data[CNT_W-1:0]  = cmp_a_q;
         ADR_CMPP: rd_data[CNT_W-1:0]  = cmp_p_q;
         default: begin
            rd_data[RD_W-1 -: CNT_W] = cnt_i;
            rd_data[1:0]             = flag_q;
         end
      endcase
   end

   assign ctrl_o  = ctrl_q;
   assign cmp_a_o = cmp_a_q;
   assign cmp_p_o = cmp_p_q;

   a_r6_match_sets_a: assert property (@(posedge clk) disable iff (!rst_n)
      match_i[0] |=> flag_q[0]);

   a_r6_match_sets_p: assert property (@(posedge clk) disable iff (!rst_n)
      match_i[1] |=> flag_q[1]);

   a_r6_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_wr && wr_data[0] && !match_i[0]) |=> !flag_q[0]);

   a_r9_cmpa_write: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADR_CMPA) |=> (cmp_a_q == $past(wr_data[CNT_W-1:0])));

   a_r9_stat_keeps_ctrl: assert property (@(posedge clk) disable iff (!rst_n)
      stat_wr |=> $stable(ctrl_q));

endmodule

// File: rtl/dcpwm_outgen.sv
module dcpwm_outgen
   import dcpwm_pkg::*;
#(
   parameter int CNT_W   = 10,
   parameter bit OUT_REG = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  mode_e            mode_i,
   input  ofunc_e           ofunc_i,
   input  logic             act_hi_i,
   input  logic             invert_i,
   input  logic [CNT_W-1:0] cnt_i,
   input  logic [CNT_W-1:0] duty_i,
   output logic             pin_o,
   output logic             oe_o
);

   logic raw;
   logic lvl;
   logic oe_c;
   logic pin_c;

   assign raw = (cnt_i < duty_i);

   always_comb begin
      unique case (ofunc_i)
         OF_INACT: lvl = ~act_hi_i;
         OF_ACT:   lvl = act_hi_i;
         default:  lvl = raw ? act_hi_i : ~act_hi_i;
      endcase
   end

   assign oe_c  = (mode_i == MODE_PWM);
   assign pin_c = oe_c & (lvl ^ invert_i);

   if (OUT_REG) begin : g_reg
      logic pin_q;
      logic oe_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pin_q <= 1'b0;
            oe_q  <= 1'b0;
         end else begin
            pin_q <= pin_c;
            oe_q  <= oe_c;
         end
      end
      assign pin_o = pin_q;
      assign oe_o  = oe_q;

      a_r2_released_q: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_i != MODE_PWM) |=> (!oe_o && !pin_o));
   end else begin : g_comb
      assign pin_o = pin_c;
      assign oe_o  = oe_c;

      a_r2_released: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_i != MODE_PWM) |-> (!oe_o && !pin_o));

      a_r8_force_inactive: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_i == MODE_PWM && ofunc_i == OF_INACT) |-> (pin_o == (~act_hi_i ^ invert_i)));

      a_r7_zero_duty: assert property (@(posedge clk) disable iff (!rst_n)
         (mode_i == MODE_PWM && ofunc_i[1] && duty_i == '0) |-> (pin_o == (~act_hi_i ^ invert_i)));
   end

endmodule

// File: rtl/dcpwm_timer.sv
module dcpwm_timer
   import dcpwm_pkg::*;
#(
   parameter int  CNT_W   = 10,
   parameter bit  OUT_REG = 1'b0,
   localparam int WR_W    = (CNT_W > CTRL_W) ? CNT_W : CTRL_W,
   localparam int RD_W    = CNT_W + 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_en,
   input  logic            wr_en,
   input  logic [1:0]      wr_addr,
   input  logic [WR_W-1:0] wr_data,
   input  logic [1:0]      rd_addr,
   output logic [RD_W-1:0] rd_data,
   output logic            pin_o,
   output logic            pin_oe
);

   if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt
      $error("dcpwm_timer: CNT_W must lie in 2..16");
   end

   ctrl_t            ctrl;
   logic [CNT_W-1:0] cmp_a;
   logic [CNT_W-1:0] cmp_p;
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] nxt;
   logic             adv;
   logic [1:0]       match;
   logic             pwm_mode;
   logic             period_is_a;
   logic [CNT_W-1:0] period;
   logic [CNT_W-1:0] duty;
   logic [CNT_W-1:0] cmp_val [2];

   // Role selection: the swap bit rules in PWM mode, the clear-select bit otherwise.
   assign pwm_mode    = (ctrl.mode == MODE_PWM);
   assign period_is_a = pwm_mode ? ctrl.swap : ctrl.clr_on_a;
   assign period      = period_is_a ? cmp_a : cmp_p;
   assign duty        = ctrl.swap ? cmp_p : cmp_a;

   assign cmp_val[0] = cmp_a;
   assign cmp_val[1] = cmp_p;

   for (genvar k = 0; k < 2; k++) begin : g_cmp
      assign match[k] = adv & (nxt == cmp_val[k]);
   end

   dcpwm_regs #(
      .CNT_W (CNT_W),
      .WR_W  (WR_W),
      .RD_W  (RD_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .cnt_i   (cnt),
      .match_i (match),
      .ctrl_o  (ctrl),
      .cmp_a_o (cmp_a),
      .cmp_p_o (cmp_p)
   );

   dcpwm_counter #(
      .CNT_W (CNT_W)
   ) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_en),
      .run_i    (ctrl.run),
      .pause_i  (ctrl.pause),
      .period_i (period),
      .cnt_o    (cnt),
      .nxt_o    (nxt),
      .adv_o    (adv)
   );

   dcpwm_outgen #(
      .CNT_W   (CNT_W),
      .OUT_REG (OUT_REG)
   ) u_out (
      .clk      (clk),
      .rst_n    (rst_n),
      .mode_i   (ctrl.mode),
      .ofunc_i  (ctrl.ofunc),
      .act_hi_i (ctrl.act_hi),
      .invert_i (ctrl.invert),
      .cnt_i    (cnt),
      .duty_i   (duty),
      .pin_o    (pin_o),
      .oe_o     (pin_oe)
   );

   a_r5_pwm_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (pwm_mode && adv && ctrl.run && !ctrl.pause && period != '0 && cnt == period)
      |=> (cnt == '0));

endmodule

// File: tb/dcpwm_timer_test.sv
module dcpwm_timer_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0;
   logic        wr_en = 1'b0;
   logic [1:0]  wr_addr = '0;
   logic [9:0]  wr_data = '0;
   logic [1:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        pin_o;
   logic        pin_oe;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   dcpwm_timer uut (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_addr (rd_addr),
      .rd_data (rd_data),
      .pin_o   (pin_o),
      .pin_oe  (pin_oe)
   );

   // Reference model built from the requirements.
   logic [9:0] m_ctrl, m_a, m_p, m_cnt;
   logic [1:0] m_fl;
   logic       m_runq;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_ctrl = '0; m_a = '0; m_p = '0; m_cnt = '0; m_fl = '0; m_runq = 1'b0;
      end else begin
         logic       run, pause, restart, adv, per_a;
         logic [9:0] per, nxt;
         logic [1:0] fl;
         run     = m_ctrl[0];
         pause   = m_ctrl[1];
         per_a   = (m_ctrl[3:2] == 2'b10) ? m_ctrl[4] : m_ctrl[5];
         per     = per_a ? m_a : m_p;
         restart = run && !m_runq;
         adv     = tick_en && run && !pause && !restart;
         nxt     = ((per != 10'd0) && (m_cnt == per)) ? 10'd0 : m_cnt + 10'd1;
         fl      = m_fl;
         if (wr_en && wr_addr == 2'd3) fl = fl & ~wr_data[1:0];
         if (adv && nxt == m_a) fl[0] = 1'b1;
         if (adv && nxt == m_p) fl[1] = 1'b1;
         m_fl = fl;
         if (restart) m_cnt = '0;
         else if (adv) m_cnt = nxt;
         m_runq = run;
         if (wr_en) begin
            case (wr_addr)
               2'd0: m_ctrl = wr_data;
               2'd1: m_a = wr_data;
               2'd2: m_p = wr_data;
               default: ;
            endcase
         end
      end
   end

   function automatic logic exp_oe();
      return m_ctrl[3:2] == 2'b10;
   endfunction

   function automatic logic exp_pin();
      logic [9:0] duty;
      logic raw, act, lvl;
      if (m_ctrl[3:2] != 2'b10) return 1'b0;
      duty = m_ctrl[4] ? m_p : m_a;
      raw  = m_cnt < duty;
      act  = m_ctrl[6];
      case (m_ctrl[9:8])
         2'b00:   lvl = !act;
         2'b01:   lvl = act;
         default: lvl = raw ? act : !act;
      endcase
      return lvl ^ m_ctrl[7];
   endfunction

   function automatic logic [15:0] exp_rd(input logic [1:0] a);
      case (a)
         2'd0: return {6'd0, m_ctrl};
         2'd1: return {6'd0, m_a};
         2'd2: return {6'd0, m_p};
         default: return {m_cnt, 4'd0, m_fl};
      endcase
   endfunction

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
      end
   endtask

   task automatic compare_model();
      string tp, tr;
      logic [15:0] er;
      if (m_ctrl[3:2] != 2'b10) tp = "R2";
      else if (!m_ctrl[9]) tp = "R8";
      else tp = "R7";
      chk(tp, {15'd0, pin_oe}, {15'd0, exp_oe()});
      chk(tp, {15'd0, pin_o}, {15'd0, exp_pin()});
      er = exp_rd(rd_addr);
      if (rd_addr != 2'd3) tr = "R9";
      else if (rd_data[15:6] !== er[15:6]) tr = "R3";
      else tr = "R6";
      chk(tr, rd_data, er);
   endtask

   task automatic step(input logic we, input logic [1:0] wa, input logic [9:0] wd,
                       input logic tk, input logic [1:0] ra);
      wr_en = we; wr_addr = wa; wr_data = wd; tick_en = tk; rd_addr = ra;
      @(negedge clk);
      compare_model();
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 2'd0, 10'd0, 1'b1, 2'd3);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL R1 watchdog: actual=hung expected=finished");
         summary();
         $finish;
      end
   end

   initial begin
      int unsigned seed_sink;
      logic [9:0] c0;
      seed_sink = $urandom(32'd4242);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1: reset state
      chk("R1", rd_data, 16'h0000);
      chk("R1", {14'd0, pin_oe, pin_o}, 16'h0000);
      step(1'b0, 2'd0, 10'd0, 1'b1, 2'd0);
      chk("R1", rd_data, 16'h0000);

      // R4/R5/R6: zero period gives a full 1024-count wrap
      step(1'b1, 2'd1, 10'd0, 1'b0, 2'd3);
      step(1'b1, 2'd2, 10'd0, 1'b0, 2'd3);
      step(1'b1, 2'd0, 10'h00D, 1'b1, 2'd3);
      idle(1);
      chk("R4", rd_data, 16'h0000);
      idle(1023);
      chk("R5", rd_data, 16'hFFC0);
      idle(1);
      chk("R5", rd_data, 16'h0003);
      step(1'b1, 2'd3, 10'h001, 1'b0, 2'd3);
      chk("R6", rd_data, 16'h0002);
      step(1'b1, 2'd3, 10'h000, 1'b0, 2'd3);
      chk("R6", rd_data, 16'h0002);
      step(1'b1, 2'd3, 10'h002, 1'b1, 2'd3);
      chk("R6", rd_data, 16'h0040);

      // R4: stop holds, restart reloads zero
      idle(4);
      step(1'b1, 2'd0, 10'h00C, 1'b1, 2'd3);
      idle(3);
      chk("R4", {6'd0, rd_data[15:6]}, 16'd6);
      step(1'b1, 2'd0, 10'h00D, 1'b1, 2'd3);
      chk("R4", {6'd0, rd_data[15:6]}, 16'd6);
      idle(1);
      chk("R4", {6'd0, rd_data[15:6]}, 16'd0);

      // R3: pause freezes, release resumes
      idle(3);
      step(1'b1, 2'd0, 10'h00F, 1'b1, 2'd3);
      idle(4);
      chk("R3", {6'd0, rd_data[15:6]}, 16'd4);
      step(1'b1, 2'd0, 10'h00D, 1'b1, 2'd3);
      idle(3);
      chk("R3", {6'd0, rd_data[15:6]}, 16'd7);
      step(1'b0, 2'd0, 10'd0, 1'b0, 2'd3);
      chk("R3", {6'd0, rd_data[15:6]}, 16'd7);

      // R7/R5: PWM, period P=4, duty A=2, active high
      step(1'b1, 2'd1, 10'd2, 1'b0, 2'd3);
      step(1'b1, 2'd2, 10'd4, 1'b0, 2'd3);
      step(1'b1, 2'd0, 10'h000, 1'b0, 2'd3);
      step(1'b1, 2'd0, 10'h249, 1'b1, 2'd3);
      for (int k = 0; k < 12; k++) begin
         idle(1);
         chk("R5", {6'd0, rd_data[15:6]}, 16'(k % 5));
         chk("R7", {15'd0, pin_o}, {15'd0, ((k % 5) < 2)});
         chk("R2", {15'd0, pin_oe}, 16'd1);
      end
      // R7: inversion, then active-low
      step(1'b1, 2'd0, 10'h2C9, 1'b1, 2'd3);
      for (int k = 0; k < 6; k++) begin
         idle(1);
         chk("R7", {15'd0, pin_o}, {15'd0, !(rd_data[15:6] < 10'd2)});
      end
      step(1'b1, 2'd0, 10'h209, 1'b1, 2'd3);
      for (int k = 0; k < 6; k++) begin
         idle(1);
         chk("R7", {15'd0, pin_o}, {15'd0, !(rd_data[15:6] < 10'd2)});
      end
      // R8: forced levels, counter keeps running
      step(1'b1, 2'd0, 10'h049, 1'b1, 2'd3);
      c0 = rd_data[15:6];
      idle(1);
      chk("R8", {15'd0, pin_o}, 16'd0);
      chk("R8", {6'd0, rd_data[15:6]}, 16'((c0 == 10'd4) ? 0 : c0 + 1));
      step(1'b1, 2'd0, 10'h149, 1'b1, 2'd3);
      chk("R8", {15'd0, pin_o}, 16'd1);
      step(1'b1, 2'd0, 10'h0C9, 1'b1, 2'd3);
      chk("R8", {15'd0, pin_o}, 16'd1);

      // R5: swapped roles, period A=2, duty P=4
      step(1'b1, 2'd0, 10'h000, 1'b0, 2'd3);
      step(1'b1, 2'd0, 10'h259, 1'b1, 2'd3);
      for (int k = 0; k < 9; k++) begin
         idle(1);
         chk("R5", {6'd0, rd_data[15:6]}, 16'(k % 3));
         chk("R7", {15'd0, pin_o}, 16'd1);
      end
      // R5: clear-select ignored in PWM mode
      step(1'b1, 2'd0, 10'h000, 1'b0, 2'd3);
      step(1'b1, 2'd0, 10'h269, 1'b1, 2'd3);
      for (int k = 0; k < 10; k++) begin
         idle(1);
         chk("R5", {6'd0, rd_data[15:6]}, 16'(k % 5));
      end
      // R5/R2: timer mode with clear on A
      step(1'b1, 2'd0, 10'h000, 1'b0, 2'd3);
      step(1'b1, 2'd0, 10'h02D, 1'b1, 2'd3);
      for (int k = 0; k < 6; k++) begin
         idle(1);
         chk("R5", {6'd0, rd_data[15:6]}, 16'(k % 3));
         chk("R2", {14'd0, pin_oe, pin_o}, 16'd0);
      end
      // R2: mode 00 released, counting on P
      step(1'b1, 2'd0, 10'h000, 1'b0, 2'd3);
      step(1'b1, 2'd0, 10'h001, 1'b1, 2'd3);
      for (int k = 0; k < 10; k++) begin
         idle(1);
         chk("R2", {6'd0, rd_data[15:6]}, 16'(k % 5));
         chk("R2", {14'd0, pin_oe, pin_o}, 16'd0);
      end

      // Constrained random phase checked against the model
      for (int i = 0; i < 30000; i++) begin
         logic        we, tk;
         logic [1:0]  wa, ra;
         logic [9:0]  wd;
         logic [31:0] r;
         we = ($urandom % 16) == 0;
         wa = 2'($urandom % 4);
         r  = $urandom;
         wd = r[9:0];
         if (wa == 2'd0) begin
            wd[0] = ($urandom % 8) != 0;
            wd[1] = ($urandom % 8) == 0;
            if ($urandom % 2) wd[3:2] = 2'b10;
         end else if (wa != 2'd3) begin
            if ($urandom % 4 != 0) wd = 10'($urandom % 12);
         end
         tk = ($urandom % 4) != 0;
         ra = 2'($urandom % 4);
         step(we, wa, wd, tk, ra);
      end

      done = 1'b1;
      summary();
      $finish;
   end

endmodule